// File: doc/BRIEF.md
# Packet-Length Weighted Round-Robin Link Arbiter

This block shares one outbound link among several routers. Each router raises its request while it has a packet waiting and presents that packet's length in flits. The arbiter picks one eligible router in round-robin order and grants it the link for exactly as many link-ready cycles as its packet has flits. A grant therefore always covers one whole packet. The weight of a router is the length of its waiting packet. A router that is not requesting, or that shows a length of zero, is passed over.

After a grant ends, the search for the next owner starts at the index just after the router that was served. No requester can be locked out. The arbiter drives a one-hot grant vector, a binary select for the data multiplexer, and a pulse that marks the cycle in which the last flit crosses the link. A link-ready input pauses the flit count without giving up the grant.

Top module: `pkt_wrr_arbiter`

## Requirements
- R1: While rst_ni is low, grant_o is all zeros, sel_o is 0 and eop_o is 0. After reset, the round-robin search starts at index 0.
- R2: When no grant is active and at least one router is eligible, a one-hot grant_o (bit i set for router i) appears one clock later. grant_o never has more than one bit set.
- R3: A router is eligible only when req_i is high and its length field len_i[i*LEN_W +: LEN_W] is non-zero. A router that requests with length zero is never granted.
- R4: The search for the next owner scans indices upward from the pointer, wrapping at N_PORTS, and grants the first eligible router it finds. After each grant ends, the pointer moves to the index just after the router that was served.
- R5: A grant lasts for exactly L cycles in which link_rdy_i is high, where L is the length sampled when the grant began. eop_o is high in the last of those cycles.
- R6: The clock after eop_o, grant_o is all zeros for one cycle. Arbitration for the next owner happens in that cycle.
- R7: The length is sampled when the grant is issued. Changes to the owner's len_i during the grant have no effect on when the grant ends.
- R8: In a cycle with link_rdy_i low, no flit is counted, eop_o stays low and the grant is held.
- R9: While a grant is active, sel_o equals the binary index of the granted router.
- R10: When all routers keep requesting, each of them is served once in every N_PORTS grants, so none is starved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_PORTS | Per-router request, held until that router's packet has been sent |
| len_i | input | N_PORTS*LEN_W | Per-router length in flits of the waiting packet; router i uses bits [i*LEN_W +: LEN_W] |
| link_rdy_i | input | 1 | Link accepts a flit this cycle |
| grant_o | output | N_PORTS | One-hot grant to the link owner |
| sel_o | output | $clog2(N_PORTS) | Binary index of the link owner, used as the mux select |
| eop_o | output | 1 | High in the cycle in which the owner's last flit is sent |

## Verification
A new grant is due one clock after the cycle in which an eligible request is seen with no grant active. eop_o is combinational and is due in the same cycle as the L-th ready cycle of the grant. The release is due one clock after eop_o. The bench drives its inputs at the falling edge and compares grant_o, sel_o and eop_o a moment later against a behavioural model. That model advances only after the rising edge, so each expectation holds for the cycle it is compared in, including stalled cycles and the idle cycle after each packet.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  typedef enum logic {CNT_IDLE = 1'b0, CNT_RUN = 1'b1} cnt_state_e;

  function automatic int wrap_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/wrr_pick.sv
module wrr_pick #(
  parameter int N_PORTS = 4,
  parameter int LEN_W   = 8,
  localparam int IDX_W  = $clog2(N_PORTS)
) (
  input  logic [IDX_W-1:0]         ptr_i,
  input  logic [N_PORTS-1:0]       req_i,
  input  logic [N_PORTS*LEN_W-1:0] len_i,
  output logic                     vld_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [N_PORTS-1:0] elig;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_elig
    assign elig[g] = req_i[g] && (len_i[g*LEN_W +: LEN_W] != '0);
  end

  // scan upward from pointer with wrap
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < N_PORTS; k++) begin
      int idx;
      idx = int'(ptr_i) + k;
      if (idx >= N_PORTS) idx = idx - N_PORTS;
      if (!vld_o && elig[idx]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(idx);
      end
    end
  end
endmodule

// File: rtl/wrr_flit_cnt.sv
module wrr_flit_cnt
  import wrr_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             rdy_i,
  output logic             run_o,
  output logic             last_o
);
  cnt_state_e       st_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;

  assign run_o  = (st_q == CNT_RUN);
  assign last_o = run_o && rdy_i && (cnt_q == len_q - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CNT_IDLE;
      len_q <= '0;
      cnt_q <= '0;
    end else if (st_q == CNT_IDLE) begin
      if (load_i) begin
        st_q  <= CNT_RUN;
        len_q <= len_i;
        cnt_q <= '0;
      end
    end else if (rdy_i) begin
      if (last_o) st_q <= CNT_IDLE;
      else        cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (cnt_q < len_q)); // R5
  AST_LEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !last_o) |=> $stable(len_q)); // R7
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !rdy_i) |=> (run_o && $stable(cnt_q))); // R8
endmodule

// File: rtl/pkt_wrr_arbiter.sv
module pkt_wrr_arbiter
  import wrr_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int LEN_W   = 8,
  localparam int IDX_W  = $clog2(N_PORTS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_PORTS-1:0]       req_i,
  input  logic [N_PORTS*LEN_W-1:0] len_i,
  input  logic                     link_rdy_i,
  output logic [N_PORTS-1:0]       grant_o,
  output logic [IDX_W-1:0]         sel_o,
  output logic                     eop_o
);
  logic [IDX_W-1:0] ptr_q, owner_q, pick_idx;
  logic             pick_vld, run, last, load;

  wrr_pick #(.N_PORTS(N_PORTS), .LEN_W(LEN_W)) u_pick (
    .ptr_i(ptr_q), .req_i(req_i), .len_i(len_i),
    .vld_o(pick_vld), .idx_o(pick_idx)
  );

  assign load = !run && pick_vld;

  wrr_flit_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .len_i(len_i[pick_idx*LEN_W +: LEN_W]), .rdy_i(link_rdy_i),
    .run_o(run), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (load) owner_q <= pick_idx;
      if (last) ptr_q   <= IDX_W'(wrap_next(int'(owner_q), N_PORTS));
    end
  end

  for (genvar g = 0; g < N_PORTS; g++) begin : g_grant
    assign grant_o[g] = run && (owner_q == IDX_W'(g));
  end

  assign sel_o = owner_q;
  assign eop_o = last;

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R2
  AST_NEW_GRANT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|grant_o) |-> ((grant_o & $past(req_i)) != '0)); // R3
  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|grant_o) && !eop_o) |=> (grant_o == $past(grant_o))); // R5
  AST_EOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> (grant_o == '0)); // R6
  AST_STALL_NO_EOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_rdy_i |-> !eop_o); // R8
  AST_SEL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o) |-> grant_o[sel_o]); // R9
endmodule

// File: tb/pkt_wrr_arbiter_tb_top.sv
module pkt_wrr_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int LW = 8;
  localparam int IW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n;
  logic [NP-1:0]    req;
  logic [NP*LW-1:0] len;
  logic             rdy;
  logic [NP-1:0]    grant;
  logic [IW-1:0]    sel;
  logic             eop;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_wrr_arbiter #(.N_PORTS(NP), .LEN_W(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .len_i(len),
    .link_rdy_i(rdy), .grant_o(grant), .sel_o(sel), .eop_o(eop)
  );

  int n_run = 0, n_fail = 0;
  int pq [NP][$];
  int zero_port = -1;
  bit scramble = 0, rnd_rdy = 0, prev_eop = 0;
  int m_busy, m_owner, m_cnt, m_len, m_ptr;
  int served [NP];
  int g_len_exp, g_rdy_cnt;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic drive();
    for (int i = 0; i < NP; i++) begin
      int l;
      bit r;
      r = pq[i].size() > 0;
      l = r ? pq[i][0] : 0;
      if (i == zero_port) begin r = 1; l = 0; end
      if (scramble && m_busy != 0 && m_owner == i) l = $urandom_range(1, 255);
      req[i] = r;
      len[i*LW +: LW] = LW'(l);
    end
    rdy = rnd_rdy ? ($urandom_range(0, 2) != 0) : 1'b1;
  endtask

  task automatic cycle();
    int e_grant;
    bit e_eop;
    @(negedge clk);
    drive();
    #1;
    e_eop   = (m_busy != 0) && rdy && (m_cnt == m_len - 1);
    e_grant = (m_busy != 0) ? (1 << m_owner) : 0;
    check(int'(grant) == e_grant, prev_eop ? "R6 grant" : (!rdy ? "R8 grant" : "R4 grant"),
          int'(grant), e_grant);
    check(eop == e_eop, !rdy ? "R8 eop" : "R5 eop", int'(eop), int'(e_eop));
    if (m_busy != 0) check(int'(sel) == m_owner, "R9 sel", int'(sel), m_owner);
    if (zero_port >= 0) check(grant[zero_port] == 1'b0, "R3 zero-length granted",
                              int'(grant[zero_port]), 0);
    prev_eop = e_eop;
    @(posedge clk);
    if (m_busy != 0) begin
      if (rdy) begin
        g_rdy_cnt++;
        if (m_cnt == m_len - 1) begin
          check(g_rdy_cnt == g_len_exp, "R7 grant length", g_rdy_cnt, g_len_exp);
          if (pq[m_owner].size() > 0) void'(pq[m_owner].pop_front());
          served[m_owner]++;
          m_busy = 0;
          m_ptr = (m_owner + 1) % NP;
        end else m_cnt++;
      end
    end else begin
      for (int k = 0; k < NP; k++) begin
        int idx;
        idx = (m_ptr + k) % NP;
        if (m_busy == 0 && req[idx] && len[idx*LW +: LW] != '0) begin
          m_busy = 1; m_owner = idx; m_cnt = 0;
          m_len = int'(len[idx*LW +: LW]);
          g_len_exp = m_len; g_rdy_cnt = 0;
        end
      end
    end
  endtask

  task automatic run_drain(input int max_cyc);
    for (int c = 0; c < max_cyc; c++) begin
      bit pend;
      pend = (m_busy != 0);
      for (int i = 0; i < NP; i++) if (pq[i].size() > 0) pend = 1;
      if (!pend) break;
      cycle();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R10 watchdog expired act=%0d exp=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    m_busy = 0; m_owner = 0; m_cnt = 0; m_len = 0; m_ptr = 0;
    for (int i = 0; i < NP; i++) served[i] = 0;
    rst_n = 1'b0; req = '0; len = '0; rdy = 1'b1;
    for (int i = 0; i < NP; i++) begin req[i] = 1'b1; len[i*LW +: LW] = 8'd5; end
    repeat (3) @(negedge clk);
    check(grant == '0, "R1 grant in reset", int'(grant), 0);
    check(sel == '0, "R1 sel in reset", int'(sel), 0);
    check(eop == 1'b0, "R1 eop in reset", int'(eop), 0);
    req = '0; len = '0;
    rst_n = 1'b1;

    // R1/R4: pointer starts at 0; routers 2 and 0 wait, 0 goes first
    pq[2].push_back(2); pq[0].push_back(3);
    run_drain(200);
    check(served[0] == 1 && served[2] == 1, "R4 both served", served[0] + served[2], 2);

    // R5: single-flit and longer packets back to back on one router
    pq[1].push_back(1); pq[1].push_back(1); pq[1].push_back(6);
    run_drain(200);

    // R10: all routers loaded, steady ready
    for (int i = 0; i < NP; i++) served[i] = 0;
    for (int p = 0; p < 5; p++)
      for (int i = 0; i < NP; i++) pq[i].push_back(1 + ((i * 3 + p * 5) % 9));
    run_drain(2000);
    for (int i = 0; i < NP; i++) check(served[i] == 5, "R10 served count", served[i], 5);

    // R8: random link stalls
    rnd_rdy = 1;
    for (int p = 0; p < 6; p++)
      for (int i = 0; i < NP; i++) pq[i].push_back(1 + ((i + p * 7) % 12));
    run_drain(5000);

    // R7: owner's length wiggles mid-grant
    scramble = 1;
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < NP; i++) pq[i].push_back(2 + ((i * 5 + p) % 7));
    run_drain(5000);
    scramble = 0; rnd_rdy = 0;

    // R3: router 2 requests with length 0 while others run
    for (int i = 0; i < NP; i++) served[i] = 0;
    zero_port = 2;
    for (int p = 0; p < 3; p++) begin
      pq[0].push_back(3); pq[1].push_back(4); pq[3].push_back(2);
    end
    run_drain(2000);
    check(served[2] == 0, "R3 zero-length never served", served[2], 0);
    repeat (5) cycle();
    zero_port = -1;
    repeat (3) cycle();

    summary();
    $finish;
  end
endmodule